// File: doc/BRIEF.md
# Per-Channel Link Test Selector with Pseudo-Random Payload

This block sits in front of an eight-lane serial transmitter and decides which lanes run a line-quality test. A test-activate bit and a 4-bit lane-select field are decoded into a requested test vector. Each lane has its own settle counter. A lane enters or leaves test mode only after the request has differed from the lane's current state for a fixed number of word strobes.

A single shared pseudo-random generator produces a 10-bit test word on every word strobe. The generator is a 15-bit linear feedback shift register with taps for x^15 + x^14 + 1. Each lane drives this shared word while it is in test mode. Lanes outside test mode forward their user word unchanged. The far-end checker that verifies the pattern is a separate block.

Top module: `bist_prbs_ctrl`

## Requirements
- R1: While `test_act` is 0, no lane is requested, whatever `test_sel` holds. After 7 strobes with this request, every lane has left test mode.
- R2: With `test_act` at 1, a `test_sel` value from 0 to 7 requests only lane k = `test_sel`, which is bit k of `test_en` and word k of `tx_data`.
- R3: With `test_act` at 1, a `test_sel` value of 8 requests all eight lanes.
- R4: With `test_act` at 1, `test_sel` values 9 to 15 request no lane. The idle default of 15 therefore means no test.
- R5: During reset and right after it, `test_en` is all zeros and every `tx_data` word equals its `user_data` word.
- R6: A lane that is out of test mode sets its `test_en` bit after the 10th consecutive strobe that requests it. It does not set the bit earlier.
- R7: A lane that is in test mode clears its `test_en` bit after the 7th consecutive strobe that does not request it. It does not clear the bit earlier.
- R8: If the request returns to the lane's current state before the count finishes, the count starts again from zero. This includes a change of the select value.
- R9: `prbs_word` holds the next 10 register output bits. Each bit is state[14] XOR state[13], and the state then shifts left with that bit entering at bit 0. The first bit produced goes to bit 9. The seed after reset is 15'h1ACE. The state advances by 10 bits on each strobe and holds between strobes.
- R10: Word k of `tx_data` (bits 10k+9 down to 10k) equals `prbs_word` when `test_en[k]` is 1, and equals word k of `user_data` when `test_en[k]` is 0.
- R11: `test_en` changes only in the cycle that follows a clock edge where `word_stb` was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_stb | input | 1 | One-cycle strobe marking a word boundary |
| test_act | input | 1 | Test activate |
| test_sel | input | 4 | Lane select: 0-7 one lane, 8 all lanes, 9-15 none |
| user_data | input | 80 | User words, lane k in bits 10k+9:10k |
| test_en | output | 8 | Per-lane test-mode flags |
| prbs_word | output | 10 | Current shared pseudo-random word |
| tx_data | output | 80 | Per-lane words sent to the serializers |

## Verification
The bench aims at the settle-count edges, with checks one strobe before and exactly at the 10th and 7th strobe. A design that is off by one would switch a cycle early or late. It interrupts a pending request partway through, so a counter that is never cleared would switch too soon. It steps the select through 8 and then into the 9-15 range, where a decoder that wraps or masks the field would wrongly enable a lane. It also holds the strobe low, so a generator or counter that advances every clock would drift away from the bench's own model of the sequence.

// File: rtl/bist_pkg.sv
package bist_pkg;
  parameter int LFSR_W = 15;
  typedef logic [LFSR_W-1:0] lfsr_t;

  // Feedback bit for x^15 + x^14 + 1.
  function automatic logic lfsr_fb(input lfsr_t s);
    return s[LFSR_W-1] ^ s[LFSR_W-2];
  endfunction

  // One shift step: drop the oldest bit and insert the feedback bit.
  function automatic lfsr_t lfsr_step(input lfsr_t s);
    return {s[LFSR_W-2:0], lfsr_fb(s)};
  endfunction
endpackage

// File: rtl/bist_sel_decode.sv
module bist_sel_decode #(
  parameter int NCH  = 8,
  parameter int SELW = 4
) (
  input  logic            act,
  input  logic [SELW-1:0] sel,
  output logic [NCH-1:0]  tgt
);
  always_comb begin
    tgt = '0;
    if (act) begin
      if (sel == SELW'(NCH)) begin
        tgt = '1;
      end else begin
        for (int i = 0; i < NCH; i++) begin
          if (sel == SELW'(i)) tgt[i] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bist_chan_delay.sv
module bist_chan_delay #(
  parameter int ON_DLY  = 10,
  parameter int OFF_DLY = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic req,
  output logic en
);
  localparam int MAXD = (ON_DLY > OFF_DLY) ? ON_DLY : OFF_DLY;
  localparam int CW   = $clog2(MAXD + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;

  assign lim_m1 = en ? CW'(OFF_DLY - 1) : CW'(ON_DLY - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en  <= 1'b0;
      cnt <= '0;
    end else if (stb) begin
      if (req == en) begin
        cnt <= '0;
      end else if (cnt == lim_m1) begin
        en  <= req;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bist_prbs_gen.sv
module bist_prbs_gen
  import bist_pkg::*;
#(
  parameter int    WW   = 10,
  parameter lfsr_t SEED = 15'h1ACE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  output logic [WW-1:0] word,
  output lfsr_t         state
);
  lfsr_t nxt;

  always_comb begin
    lfsr_t s;
    s    = state;
    word = '0;
    for (int k = 0; k < WW; k++) begin
      word[WW-1-k] = lfsr_fb(s);
      s = lfsr_step(s);
    end
    nxt = s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   state <= SEED;
    else if (stb) state <= nxt;
  end
endmodule

// File: rtl/bist_prbs_ctrl.sv
module bist_prbs_ctrl
  import bist_pkg::*;
#(
  parameter int    NCH     = 8,
  parameter int    WW      = 10,
  parameter int    SELW    = 4,
  parameter int    ON_DLY  = 10,
  parameter int    OFF_DLY = 7,
  parameter lfsr_t SEED    = 15'h1ACE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_stb,
  input  logic              test_act,
  input  logic [SELW-1:0]   test_sel,
  input  logic [NCH*WW-1:0] user_data,
  output logic [NCH-1:0]    test_en,
  output logic [WW-1:0]     prbs_word,
  output logic [NCH*WW-1:0] tx_data
);
  logic [NCH-1:0] tgt_vec;
  lfsr_t          lfsr_q;

  bist_sel_decode #(.NCH(NCH), .SELW(SELW)) u_dec (
    .act (test_act),
    .sel (test_sel),
    .tgt (tgt_vec)
  );

  bist_prbs_gen #(.WW(WW), .SEED(SEED)) u_prbs (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (word_stb),
    .word  (prbs_word),
    .state (lfsr_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    bist_chan_delay #(.ON_DLY(ON_DLY), .OFF_DLY(OFF_DLY)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (word_stb),
      .req   (tgt_vec[g]),
      .en    (test_en[g])
    );
    assign tx_data[g*WW +: WW] = test_en[g] ? prbs_word : user_data[g*WW +: WW];
  end
endmodule

// File: rtl/bist_prbs_ctrl_chk.sv
module bist_prbs_ctrl_chk #(
  parameter int NCH  = 8,
  parameter int SELW = 4,
  parameter int LW   = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            word_stb,
  input logic            test_act,
  input logic [SELW-1:0] test_sel,
  input logic [NCH-1:0]  tgt_vec,
  input logic [NCH-1:0]  test_en,
  input logic [LW-1:0]   lfsr_q
);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !test_act |-> tgt_vec == '0);

  p_bad_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (test_act && test_sel > SELW'(NCH)) |-> tgt_vec == '0);

  p_rise_requested_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (test_en & ~$past(test_en) & ~$past(tgt_vec)) == '0);

  p_fall_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (~test_en & $past(test_en) & $past(tgt_vec)) == '0);

  p_hold_no_stb_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |=> $stable(test_en));

  p_lfsr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !word_stb |=> $stable(lfsr_q));

  p_lfsr_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

bind bist_prbs_ctrl bist_prbs_ctrl_chk #(.NCH(NCH), .SELW(SELW), .LW(15)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .word_stb (word_stb),
  .test_act (test_act),
  .test_sel (test_sel),
  .tgt_vec  (tgt_vec),
  .test_en  (test_en),
  .lfsr_q   (lfsr_q)
);

// File: tb/bist_prbs_ctrl_test.sv
module bist_prbs_ctrl_test;
  localparam int NCH = 8;
  localparam int WW  = 10;
  localparam logic [14:0] SEED = 15'h1ACE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_stb = 1'b0;
  logic test_act = 1'b0;
  logic [3:0] test_sel = 4'hF;
  logic [NCH*WW-1:0] user_data = '0;
  logic [NCH-1:0] test_en;
  logic [WW-1:0] prbs_word;
  logic [NCH*WW-1:0] tx_data;

  int n_tests = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bist_prbs_ctrl uut (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .test_act(test_act),
    .test_sel(test_sel), .user_data(user_data), .test_en(test_en),
    .prbs_word(prbs_word), .tx_data(tx_data)
  );

  // Behavioural reference model
  bit [NCH-1:0] m_en;
  int m_cnt [NCH];
  bit [14:0] m_state;

  function automatic bit [NCH-1:0] want(bit act, int sel);
    bit [NCH-1:0] r = '0;
    if (act && sel == 8) r = '1;
    else if (act && sel < 8) r[sel] = 1'b1;
    return r;
  endfunction

  function automatic bit [WW-1:0] model_word(bit [14:0] s);
    bit [WW-1:0] w;
    bit b;
    for (int k = 0; k < WW; k++) begin
      b = s[14] ^ s[13];
      w[WW-1-k] = b;
      s = {s[13:0], b};
    end
    return w;
  endfunction

  function automatic bit [14:0] model_adv(bit [14:0] s);
    bit b;
    for (int k = 0; k < WW; k++) begin
      b = s[14] ^ s[13];
      s = {s[13:0], b};
    end
    return s;
  endfunction

  always @(posedge clk) begin
    bit [NCH-1:0] w;
    if (!rst_n) begin
      m_en = '0;
      m_state = SEED;
      for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
    end else if (word_stb) begin
      w = want(test_act, int'(test_sel));
      for (int i = 0; i < NCH; i++) begin
        if (w[i] == m_en[i]) m_cnt[i] = 0;
        else begin
          m_cnt[i]++;
          if (m_cnt[i] == (m_en[i] ? 7 : 10)) begin
            m_en[i] = w[i];
            m_cnt[i] = 0;
          end
        end
      end
      m_state = model_adv(m_state);
    end
  end

  task automatic check(string tag, logic [NCH*WW-1:0] act_v, logic [NCH*WW-1:0] exp_v);
    n_tests++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R6/R7 en", {{(NCH*WW-NCH){1'b0}}, test_en}, {{(NCH*WW-NCH){1'b0}}, m_en});
      check("R9 prbs", {{(NCH*WW-WW){1'b0}}, prbs_word},
            {{(NCH*WW-WW){1'b0}}, model_word(m_state)});
      for (int i = 0; i < NCH; i++)
        check("R10 lane", {{(NCH*WW-WW){1'b0}}, tx_data[i*WW +: WW]},
              {{(NCH*WW-WW){1'b0}}, m_en[i] ? model_word(m_state) : user_data[i*WW +: WW]});
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_en(string tag, logic [NCH-1:0] exp_v);
    check(tag, {{(NCH*WW-NCH){1'b0}}, test_en}, {{(NCH*WW-NCH){1'b0}}, exp_v});
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) user_data[i*WW +: WW] = WW'(37 * i + 5);
    step(3);
    chk_en("R5 reset en", 8'h00);
    check("R5 reset data", tx_data, user_data);
    rst_n = 1'b1;
    step(1);
    chk_en("R5 after reset", 8'h00);
    check("R9 seed word", {{(NCH*WW-WW){1'b0}}, prbs_word},
          {{(NCH*WW-WW){1'b0}}, model_word(SEED)});

    // R2 / R6: lane 3 enable takes exactly 10 strobes
    word_stb = 1'b1; test_act = 1'b1; test_sel = 4'd3;
    step(9);  chk_en("R6 before 10th", 8'h00);
    step(1);  chk_en("R2 lane 3 on", 8'h08);
    user_data = {NCH{10'h2B6}};
    step(2);

    // R3: select all lanes
    test_sel = 4'd8;
    step(9);  chk_en("R3 before 10th", 8'h08);
    step(1);  chk_en("R3 all on", 8'hFF);

    // R4 / R7: invalid select releases after 7 strobes
    test_sel = 4'd12;
    step(6);  chk_en("R7 before 7th", 8'hFF);
    step(1);  chk_en("R4 sel 12 none", 8'h00);
    test_sel = 4'd15;
    step(12); chk_en("R4 default none", 8'h00);

    // R1: activate low overrides select 8
    test_act = 1'b0; test_sel = 4'd8;
    step(12); chk_en("R1 act low", 8'h00);

    // R8: interrupted request restarts the count
    test_act = 1'b1; test_sel = 4'd5;
    step(6);
    test_sel = 4'd9;
    step(1);
    test_sel = 4'd5;
    step(9);  chk_en("R8 restart not yet", 8'h00);
    step(1);  chk_en("R8 lane 5 on", 8'h20);

    // R8: select change moves lane, old lane releases after 7, new on after 10
    test_sel = 4'd0;
    step(7);  chk_en("R8 lane 5 off", 8'h00);
    step(3);  chk_en("R2 lane 0 on", 8'h01);

    // R11 / R9: no strobe, nothing moves
    word_stb = 1'b0; test_sel = 4'd7;
    begin
      logic [WW-1:0] held;
      held = prbs_word;
      step(15);
      chk_en("R11 held", 8'h01);
      check("R9 word held", {{(NCH*WW-WW){1'b0}}, prbs_word}, {{(NCH*WW-WW){1'b0}}, held});
    end

    // Sparse strobes: one in three cycles
    for (int k = 0; k < 36; k++) begin
      word_stb = (k % 3 == 0);
      user_data[7*WW +: WW] = WW'(k * 13);
      step(1);
    end
    word_stb = 1'b0;
    chk_en("R2 lane 7 sparse", 8'h80);
    step(2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule